// File: doc/BRIEF.md
# Dual-Source I2C Master Clock Generator

This block produces the SCL waveform that an I2C master drives onto the bus. A select input picks one of two timing sources. The first is an 8-bit up-counter that restarts from a programmable start value and flips SCL on every wrap. The second is a phase sequencer that holds SCL low for one programmed number of clock cycles and releases it for another, so the duty cycle can be uneven.

The output is an open-drain pull-down request. The block also watches the real line level, so a slave that holds SCL low stretches the high phase of the phase sequencer. When the master-active input is low, for example while the interface acts as a slave, the block stops, clears its counters and releases the line, whatever the select input says.

Top module: `scl_rate_gen`

## Requirements
- R1: While `master_en` is 0, `scl_pull_low` is 0 whatever the value of `src_timer`.
- R2: With `src_timer`=1, the counter counts up from `tmr_start` and wraps after 255, so each SCL level lasts 256 − `tmr_start` cycles and the bit period is 2 × (256 − `tmr_start`).
- R3: With `src_timer`=1, a `tmr_start` of 255 gives 1-cycle levels and a `tmr_start` of 0 gives 256-cycle levels.
- R4: With `src_timer`=0, each low phase lasts max(`lo_cycles`, 4) cycles.
- R5: With `src_timer`=0, each released phase lasts max(`hi_cycles`, 4) cycles while the line stays high, and the low and high times are set independently.
- R6: Programmed counts of 0 to 3 act as 4.
- R7: In the phase sequencer, cycles in which `scl_in` is 0 during the released phase are not counted, so the released phase grows by the length of the stretch.
- R8: Clearing `master_en` releases SCL in the same cycle and resets the counters.
- R9: After `master_en` rises with `src_timer`=0, SCL stays released for max(`hi_cycles`, 4) cycles and then goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous reset, active low |
| master_en | input | 1 | Master mode is active, so SCL is generated |
| src_timer | input | 1 | 1: wrapping timer source; 0: phase sequencer |
| tmr_start | input | 8 | Start value loaded into the timer at each wrap |
| hi_cycles | input | 8 | Released-phase length in cycles |
| lo_cycles | input | 8 | Low-phase length in cycles |
| scl_in | input | 1 | Sensed SCL line level |
| scl_pull_low | output | 1 | 1 pulls SCL low; 0 releases it |

## Verification
`scl_pull_low` is formed from registers without a further output stage. A change to `master_en` therefore shows at the output in the same cycle. A wrap or the end of a phase shows one clock edge after the counter reaches its limit. Every output is sampled on the falling edge. Phase lengths are counted as falling edges at a constant level, and counting starts at the first full segment, so the phase after start-up is never measured. The line model in the bench combines the pull-down with an external hold. This lets a stretch be placed at an exact falling edge, and its expected length is the stretch plus the high count.

// File: rtl/scl_rate_pkg.sv
// Shared types and constants for the SCL rate generator.
package scl_rate_pkg;
    // Phase of the internal sequencer: line released or line pulled low.
    typedef enum logic {
        PH_RELEASED = 1'b0,
        PH_PULLED   = 1'b1
    } phase_e;

    // Smallest phase length honoured by the sequencer, in clock cycles.
    localparam int unsigned MIN_PHASE = 4;
endpackage

// File: rtl/scl_wrap_timer.sv
// Auto-reload up-counter. While enabled it counts up from the start value.
// Each time it passes its top value it reloads the start value and raises a
// one-cycle wrap pulse. While disabled it holds the start value and stays silent.
// Assumes: start value may change at any time and is used at the next reload.
module scl_wrap_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [W-1:0] start_val,
    output logic         wrap
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    logic [W-1:0] cnt_q;

    // Count, reload on wrap, and emit the registered wrap pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= start_val;
            wrap  <= 1'b0;
        end else if (cnt_q == TOP) begin
            cnt_q <= start_val;
            wrap  <= 1'b1;
        end else begin
            cnt_q <= cnt_q + 1'b1;
            wrap  <= 1'b0;
        end
    end

    // R2: a wrap pulse coincides with the counter holding the reloaded value.
    p_reload_on_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && wrap) |-> (cnt_q == $past(start_val)));

    // R1: a stopped timer never produces a wrap.
    p_quiet_when_stopped_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !wrap);
endmodule

// File: rtl/scl_phase_seq.sv
// Internal SCL sequencer. It alternates a released phase and a pulled phase,
// each timed in clock cycles from its own count (raised to MIN_PHASE if smaller).
// The released phase counts only cycles where the sensed line is high, so a
// slave or another master holding SCL low extends it. Starts in the released
// phase whenever it is enabled.
module scl_phase_seq
    import scl_rate_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [W-1:0] hi_len,
    input  logic [W-1:0] lo_len,
    input  logic         line_high,
    output logic         pull
);
    localparam logic [W-1:0] MIN_V = W'(MIN_PHASE);

    phase_e       ph_q;
    logic [W-1:0] cnt_q;
    logic [W-1:0] hi_eff, lo_eff;

    // Clamp the programmed lengths to the minimum phase.
    always_comb begin
        hi_eff = (hi_len < MIN_V) ? MIN_V : hi_len;
        lo_eff = (lo_len < MIN_V) ? MIN_V : lo_len;
    end

    // Advance the phase counter and switch phases at each phase end.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            ph_q  <= PH_RELEASED;
            cnt_q <= '0;
        end else if (ph_q == PH_PULLED) begin
            if (cnt_q >= lo_eff - 1'b1) begin
                ph_q  <= PH_RELEASED;
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end else if (line_high) begin
            if (cnt_q >= hi_eff - 1'b1) begin
                ph_q  <= PH_PULLED;
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign pull = (ph_q == PH_PULLED);

    // R7: a released phase does not advance while the line is held low.
    p_stretch_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && ph_q == PH_RELEASED && !line_high) |=> (!run || cnt_q == $past(cnt_q)));

    // R8: a stopped sequencer is cleared back to the released phase.
    p_clear_when_stopped_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (ph_q == PH_RELEASED && cnt_q == '0));

    // R4: the pulled phase count stays inside its effective length.
    p_low_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_PULLED && $stable(lo_len)) |-> (cnt_q < lo_eff));
endmodule

// File: rtl/scl_drive_mux.sv
// Output stage. It keeps the toggle flop for the timer source and picks the
// source named by the select input. The pull-down is forced off while the
// master is inactive, so the select input has no effect in that state.
module scl_drive_mux (
    input  logic clk,
    input  logic rst_n,
    input  logic master_en,
    input  logic use_timer,
    input  logic wrap,
    input  logic seq_pull,
    output logic pull_low
);
    logic tog_q;
    logic tmr_mode;

    assign tmr_mode = master_en && use_timer;

    // Flip the timer-driven level on every wrap; clear it outside timer mode.
    always_ff @(posedge clk) begin
        if (!rst_n || !tmr_mode) begin
            tog_q <= 1'b0;
        end else if (wrap) begin
            tog_q <= ~tog_q;
        end
    end

    // Select the active source and gate it with master mode.
    always_comb begin
        pull_low = 1'b0;
        if (master_en) begin
            pull_low = use_timer ? tog_q : seq_pull;
        end
    end

    // R2: in timer mode the level changes only on a wrap.
    p_toggle_only_on_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_mode && !wrap) |=> (!tmr_mode || tog_q == $past(tog_q)));

    // R1: no pull-down is requested while the master is inactive.
    p_release_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !master_en |-> !pull_low);
endmodule

// File: rtl/scl_rate_gen.sv
// SCL rate generator top. It joins the wrapping timer, the phase sequencer and
// the output stage. Only one source runs at a time, picked by src_timer, and
// only while master_en is high. Assumes scl_in is already synchronous to clk.
module scl_rate_gen #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         master_en,
    input  logic         src_timer,
    input  logic [W-1:0] tmr_start,
    input  logic [W-1:0] hi_cycles,
    input  logic [W-1:0] lo_cycles,
    input  logic         scl_in,
    output logic         scl_pull_low
);
    logic tmr_run, seq_run, wrap, seq_pull;

    // Only the selected source runs, and only in master mode.
    assign tmr_run = master_en &&  src_timer;
    assign seq_run = master_en && !src_timer;

    scl_wrap_timer #(.W(W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (tmr_run),
        .start_val (tmr_start),
        .wrap      (wrap)
    );

    scl_phase_seq #(.W(W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (seq_run),
        .hi_len    (hi_cycles),
        .lo_len    (lo_cycles),
        .line_high (scl_in),
        .pull      (seq_pull)
    );

    scl_drive_mux u_mux (
        .clk       (clk),
        .rst_n     (rst_n),
        .master_en (master_en),
        .use_timer (src_timer),
        .wrap      (wrap),
        .seq_pull  (seq_pull),
        .pull_low  (scl_pull_low)
    );
endmodule

// File: tb/tb_scl_rate_gen.sv
module tb_scl_rate_gen;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       master_en = 1'b0;
    logic       src_timer = 1'b0;
    logic [7:0] tmr_start = 8'd0;
    logic [7:0] hi_cycles = 8'd10;
    logic [7:0] lo_cycles = 8'd10;
    logic       ext_hold = 1'b0;
    logic       scl_in;
    logic       scl_pull_low;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Wired-AND line model: released only when neither side pulls low.
    assign scl_in = ~(scl_pull_low | ext_hold);

    scl_rate_gen dut (
        .clk(clk), .rst_n(rst_n), .master_en(master_en), .src_timer(src_timer),
        .tmr_start(tmr_start), .hi_cycles(hi_cycles), .lo_cycles(lo_cycles),
        .scl_in(scl_in), .scl_pull_low(scl_pull_low)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // Length of the next complete segment where scl_pull_low == lvl.
    task automatic seg_len(input logic lvl, output int n);
        n = 0;
        while (scl_pull_low == lvl) @(negedge clk);
        while (scl_pull_low != lvl) @(negedge clk);
        while (scl_pull_low == lvl) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic stop_master();
        @(negedge clk);
        master_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 reset", int'(scl_pull_low), 0);
    endtask

    task automatic t_idle();
        int seen = 0;
        for (int s = 0; s < 2; s++) begin
            src_timer = s[0];
            tmr_start = 8'd255;
            for (int i = 0; i < 40; i++) begin
                @(negedge clk);
                if (scl_pull_low) seen++;
            end
        end
        check("R1 idle ignores select", seen, 0);
    endtask

    task automatic t_timer(input logic [7:0] start, input string req);
        int lo, hi;
        @(negedge clk);
        src_timer = 1'b1; tmr_start = start; master_en = 1'b1;
        seg_len(1'b1, lo);
        seg_len(1'b0, hi);
        check({req, " timer low level"},  lo, 256 - int'(start));
        check({req, " timer high level"}, hi, 256 - int'(start));
        stop_master();
    endtask

    task automatic t_seq(input logic [7:0] h, input logic [7:0] l,
                         input int eh, input int el, input string req);
        int lo, hi;
        @(negedge clk);
        src_timer = 1'b0; hi_cycles = h; lo_cycles = l; master_en = 1'b1;
        seg_len(1'b1, lo);
        seg_len(1'b0, hi);
        check({req, " low phase"},  lo, el);
        check({req, " high phase"}, hi, eh);
        stop_master();
    endtask

    task automatic t_stretch();
        int n = 0;
        @(negedge clk);
        src_timer = 1'b0; hi_cycles = 8'd6; lo_cycles = 8'd8; master_en = 1'b1;
        while (scl_pull_low == 1'b0) @(negedge clk);
        while (scl_pull_low == 1'b1) @(negedge clk);
        ext_hold = 1'b1;
        for (int i = 0; i < 15; i++) begin
            n++;
            @(negedge clk);
        end
        ext_hold = 1'b0;
        while (scl_pull_low == 1'b0) begin
            n++;
            @(negedge clk);
        end
        check("R7 stretched high phase", n, 15 + 6);
        stop_master();
    endtask

    task automatic t_disable_restart();
        int n = 0;
        @(negedge clk);
        src_timer = 1'b0; hi_cycles = 8'd7; lo_cycles = 8'd30; master_en = 1'b1;
        while (scl_pull_low == 1'b0) @(negedge clk);
        repeat (3) @(negedge clk);
        master_en = 1'b0;
        #1;
        check("R8 release in same cycle", int'(scl_pull_low), 0);
        repeat (5) @(negedge clk);
        master_en = 1'b1;
        @(negedge clk);
        n = 1;
        while (scl_pull_low == 1'b0 && n < 100) begin
            n++;
            @(negedge clk);
        end
        check("R9 first low after high count", n, 7);
        stop_master();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_idle();
        t_timer(8'd250, "R2");
        t_timer(8'd200, "R2");
        t_timer(8'd255, "R3");
        t_timer(8'd0,   "R3");
        t_seq(8'd10, 8'd20, 10, 20, "R4 R5");
        t_seq(8'd5,  8'd40,  5, 40, "R5 asym");
        t_seq(8'd1,  8'd0,   4,  4, "R6");
        t_seq(8'd3,  8'd4,   4,  4, "R6 edge");
        t_stretch();
        t_disable_restart();
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end
endmodule